// File: doc/BRIEF.md
# Color-Lookup Pixel Shifter

This block turns a stream of 32-bit packed pixel words into a paced stream of 24-bit RGB colors. Each accepted word is unpacked from its least significant bits upward into indices of 1, 2, 4 or 8 bits. Every index addresses a 256-entry table of 32-bit color words. The low 24 bits of the entry that was read leave the block as separate red, green and blue bytes for a DAC or for pins.

The color table has one RAM port, and two users take turns on it. Even cycles belong to the video path, which reads one pixel per turn. Odd cycles belong to the table writer. The pixel rate is therefore half the clock rate, and table updates never collide with pixel reads.

The word input is a valid/ready stream. The producer holds `word_valid` and `word_data` steady until `word_ready` is seen high at a clock edge. The block raises `word_ready` only when the current word is used up, so a word is never dropped or overwritten. The table write port follows the same rules: a write completes only on a cycle where `tbl_wr_ready` is high.

Top module: `pix_clut_shifter`

## Requirements
- R1: While reset is asserted, the RGB outputs are zero, `rgb_valid` and `underrun` are low, `word_ready` is high and `tbl_wr_ready` is low.
- R2: After reset is released, the first cycle is a video slot with `tbl_wr_ready` low. From then on `tbl_wr_ready` alternates every cycle, high on the odd cycles that belong to the table writer.
- R3: `bpp_mode` sets the pixel width: 0 gives 1 bit, 1 gives 2, 2 gives 4 and 3 gives 8. The width is captured when a word is accepted and applies to that whole word, even if `bpp_mode` changes while the word is being shifted.
- R4: Pixels are taken from bit 0 of the word upward. The value of each field, zero-extended, is the table index.
- R5: `word_ready` is high exactly when no pixels of the last accepted word remain. An accepted word yields 32/width pixels. After that, `word_ready` rises again.
- R6: Each video slot with a pixel available reads exactly one table entry. Its color appears on the outputs one clock later, with `rgb_valid` high for one cycle. `rgb_valid` is never high on two cycles in a row, and the RGB outputs change only on a cycle where `rgb_valid` is high.
- R7: From the table entry read, red is bits 23:16, green is bits 15:8 and blue is bits 7:0. Bits 31:24 have no effect on the outputs.
- R8: A table write completes when `tbl_wr_valid` and `tbl_wr_ready` are both high at a clock edge. Every pixel read after that edge sees the new entry.
- R9: A video slot with no pixel available produces a one-cycle `underrun` pulse one clock later, with `rgb_valid` low. The RGB outputs keep the last color.
- R10: If the producer keeps `word_valid` high, no underrun occurs between words. The next word is taken in the writer's slot that follows the last pixel read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| word_valid | input | 1 | Pixel word offered |
| word_ready | output | 1 | Block can take a pixel word |
| word_data | input | 32 | Packed pixel word, first pixel in the low bits |
| bpp_mode | input | 2 | Pixel width select: 0/1/2/3 gives 1/2/4/8 bits |
| tbl_wr_valid | input | 1 | Table write offered |
| tbl_wr_ready | output | 1 | Writer owns the RAM port this cycle |
| tbl_wr_addr | input | 8 | Table entry to write |
| tbl_wr_data | input | 32 | Color word to store |
| rgb_r | output | 8 | Red channel |
| rgb_g | output | 8 | Green channel |
| rgb_b | output | 8 | Blue channel |
| rgb_valid | output | 1 | A new color is on the outputs this cycle |
| underrun | output | 1 | A pixel slot passed with no data |

## Verification
The bench builds the block with its default parameters: 32-bit words, 8-bit indices and the full 256-entry table. This makes every width mode reachable, including 8-bit indices that address the whole table, as well as words split into 32, 16, 8 or 4 pixels. Random word streams change the pixel width from word to word and interleave table rewrites with pixel reads. Directed phases cover starvation straight after reset, a single word drained to empty, a gap-free word stream and a table entry whose top byte alone is set.

// File: rtl/pcs_pkg.sv
package pcs_pkg;

  // Pixel width select: the encoding is the log2 of the width in bits.
  typedef enum logic [1:0] {
    BPP_1 = 2'd0,
    BPP_2 = 2'd1,
    BPP_4 = 2'd2,
    BPP_8 = 2'd3
  } bpp_e;

  // Number of channels split out of a table entry.
  localparam int unsigned NUM_CHAN = 3;

  function automatic int unsigned pix_bits(bpp_e m);
    return 32'd1 << m;
  endfunction

endpackage

// File: rtl/pcs_slot_arb.sv
// Splits the single color RAM port between the video path and the table
// writer: even cycles after reset go to video, odd cycles to the writer.
module pcs_slot_arb (
  input  logic clk,
  input  logic rst_n,
  output logic video_slot,
  output logic core_slot
);

  logic phase_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase_q <= 1'b0;
    else        phase_q <= ~phase_q;
  end

  assign video_slot = ~phase_q;
  assign core_slot  = phase_q;

endmodule

// File: rtl/pcs_unpacker.sv
// Holds one packed word and hands out one index per video slot, starting
// from the low bits. The width is captured with the word.
module pcs_unpacker
  import pcs_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter int IDX_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              video_slot,
  input  logic              word_valid,
  output logic              word_ready,
  input  logic [WORD_W-1:0] word_data,
  input  logic [1:0]        bpp_mode,
  output logic              rd_en,
  output logic [IDX_W-1:0]  rd_idx
);

  localparam int CNT_W = $clog2(WORD_W) + 1;

  logic [WORD_W-1:0] shreg_q;
  logic [CNT_W-1:0]  left_q;
  bpp_e              mode_q;
  logic [3:0]        step_bits;
  logic [IDX_W-1:0]  mask;
  logic              take;

  always_comb begin
    step_bits = 4'(pix_bits(mode_q));
    mask      = IDX_W'((32'd1 << step_bits) - 32'd1);
  end

  assign word_ready = (left_q == '0);
  assign take       = word_valid && word_ready;
  assign rd_en      = video_slot && !word_ready;
  assign rd_idx     = shreg_q[IDX_W-1:0] & mask;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg_q <= '0;
      left_q  <= '0;
      mode_q  <= BPP_1;
    end else if (take) begin
      shreg_q <= word_data;
      left_q  <= CNT_W'(WORD_W / pix_bits(bpp_e'(bpp_mode)));
      mode_q  <= bpp_e'(bpp_mode);
    end else if (rd_en) begin
      shreg_q <= shreg_q >> step_bits;
      left_q  <= left_q - 1'b1;
    end
  end

endmodule

// File: rtl/pcs_clut_ram.sv
// Single-port color table: one synchronous read or one write per cycle,
// chosen by the slot owner. The read register holds its value between reads.
module pcs_clut_ram #(
  parameter int IDX_W  = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  input  logic [IDX_W-1:0]  rd_addr,
  output logic [DATA_W-1:0] rd_data
);

  localparam int ENTRIES = 1 << IDX_W;

  logic [DATA_W-1:0] mem [ENTRIES];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rd_data <= '0;
    else if (rd_en) rd_data <= mem[rd_addr];
  end

endmodule

// File: rtl/pcs_rgb_stage.sv
// Splits the held table word into channels and times the strobes to the
// read that produced it.
module pcs_rgb_stage
  import pcs_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int COLOR_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               video_slot,
  input  logic               rd_en,
  input  logic [DATA_W-1:0]  rd_data,
  output logic [COLOR_W-1:0] chan [NUM_CHAN],
  output logic               pix_valid,
  output logic               starved
);

  for (genvar c = 0; c < NUM_CHAN; c++) begin : g_chan
    assign chan[c] = rd_data[c*COLOR_W +: COLOR_W];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pix_valid <= 1'b0;
      starved   <= 1'b0;
    end else begin
      pix_valid <= rd_en;
      starved   <= video_slot && !rd_en;
    end
  end

endmodule

// File: rtl/pix_clut_shifter.sv
module pix_clut_shifter
  import pcs_pkg::*;
#(
  parameter int WORD_W  = 32,
  parameter int IDX_W   = 8,
  parameter int COLOR_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               word_valid,
  output logic               word_ready,
  input  logic [WORD_W-1:0]  word_data,
  input  logic [1:0]         bpp_mode,
  input  logic               tbl_wr_valid,
  output logic               tbl_wr_ready,
  input  logic [IDX_W-1:0]   tbl_wr_addr,
  input  logic [WORD_W-1:0]  tbl_wr_data,
  output logic [COLOR_W-1:0] rgb_r,
  output logic [COLOR_W-1:0] rgb_g,
  output logic [COLOR_W-1:0] rgb_b,
  output logic               rgb_valid,
  output logic               underrun
);

  logic               video_slot;
  logic               core_slot;
  logic               rd_en;
  logic [IDX_W-1:0]   rd_idx;
  logic [WORD_W-1:0]  rd_data;
  logic [COLOR_W-1:0] chan [NUM_CHAN];

  pcs_slot_arb u_slot (
    .clk        (clk),
    .rst_n      (rst_n),
    .video_slot (video_slot),
    .core_slot  (core_slot)
  );

  pcs_unpacker #(.WORD_W(WORD_W), .IDX_W(IDX_W)) u_unpack (
    .clk        (clk),
    .rst_n      (rst_n),
    .video_slot (video_slot),
    .word_valid (word_valid),
    .word_ready (word_ready),
    .word_data  (word_data),
    .bpp_mode   (bpp_mode),
    .rd_en      (rd_en),
    .rd_idx     (rd_idx)
  );

  pcs_clut_ram #(.IDX_W(IDX_W), .DATA_W(WORD_W)) u_ram (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (tbl_wr_valid && core_slot),
    .wr_addr (tbl_wr_addr),
    .wr_data (tbl_wr_data),
    .rd_en   (rd_en),
    .rd_addr (rd_idx),
    .rd_data (rd_data)
  );

  pcs_rgb_stage #(.DATA_W(WORD_W), .COLOR_W(COLOR_W)) u_out (
    .clk        (clk),
    .rst_n      (rst_n),
    .video_slot (video_slot),
    .rd_en      (rd_en),
    .rd_data    (rd_data),
    .chan       (chan),
    .pix_valid  (rgb_valid),
    .starved    (underrun)
  );

  assign tbl_wr_ready = core_slot;
  assign rgb_b        = chan[0];
  assign rgb_g        = chan[1];
  assign rgb_r        = chan[2];

endmodule

// File: rtl/pcs_checker.sv
module pcs_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        word_valid,
  input logic        word_ready,
  input logic        tbl_wr_ready,
  input logic        rgb_valid,
  input logic        underrun,
  input logic [23:0] rgb
);

  AST_SLOT_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
    tbl_wr_ready |=> !tbl_wr_ready); // R2

  AST_SLOT_RETURN: assert property (@(posedge clk) disable iff (!rst_n)
    !tbl_wr_ready |=> tbl_wr_ready); // R2

  AST_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (word_valid && word_ready) |=> !word_ready); // R5

  AST_PIXEL_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
    rgb_valid |=> !rgb_valid); // R6

  AST_OUT_AFTER_VIDEO: assert property (@(posedge clk) disable iff (!rst_n)
    (rgb_valid || underrun) |-> tbl_wr_ready); // R6

  AST_COLOR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !rgb_valid |-> $stable(rgb)); // R9

  AST_STARVE_NO_PIXEL: assert property (@(posedge clk) disable iff (!rst_n)
    underrun |-> !rgb_valid); // R9

endmodule

bind pix_clut_shifter pcs_checker u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .word_valid   (word_valid),
  .word_ready   (word_ready),
  .tbl_wr_ready (tbl_wr_ready),
  .rgb_valid    (rgb_valid),
  .underrun     (underrun),
  .rgb          ({rgb_r, rgb_g, rgb_b})
);

// File: tb/pix_clut_shifter_tb.sv
`timescale 1ns/1ps
module pix_clut_shifter_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        word_valid = 1'b0;
  logic        word_ready;
  logic [31:0] word_data = '0;
  logic [1:0]  bpp_mode = 2'd3;
  logic        tbl_wr_valid = 1'b0;
  logic        tbl_wr_ready;
  logic [7:0]  tbl_wr_addr = '0;
  logic [31:0] tbl_wr_data = '0;
  logic [7:0]  rgb_r, rgb_g, rgb_b;
  logic        rgb_valid;
  logic        underrun;

  always #2.5 clk = ~clk;

  pix_clut_shifter u_dut (
    .clk          (clk),
    .rst_n        (rst_n),
    .word_valid   (word_valid),
    .word_ready   (word_ready),
    .word_data    (word_data),
    .bpp_mode     (bpp_mode),
    .tbl_wr_valid (tbl_wr_valid),
    .tbl_wr_ready (tbl_wr_ready),
    .tbl_wr_addr  (tbl_wr_addr),
    .tbl_wr_data  (tbl_wr_data),
    .rgb_r        (rgb_r),
    .rgb_g        (rgb_g),
    .rgb_b        (rgb_b),
    .rgb_valid    (rgb_valid),
    .underrun     (underrun)
  );

  int          checks = 0;
  int          fails = 0;
  bit          done = 0;
  int          cyc = 0;
  logic [31:0] tbl [256];
  int          expq [$];
  logic [31:0] wq [$];
  logic [39:0] wrq [$];
  bit          feed = 0;
  int          gap_pct = 0;
  bit          rand_mode = 0;
  bit          w_hs = 0;
  bit          t_hs = 0;
  int          hs_count = 0;
  int          under_cnt = 0;
  int          under_armed = 0;
  logic [23:0] last_rgb = '0;

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Expected indices of one word: low bits first (R3, R4).
  function automatic void push_word(logic [31:0] w, int m);
    int wb = 1 << m;
    for (int i = 0; i < 32 / wb; i++)
      expq.push_back(int'((w >> (i * wb)) & ((32'd1 << wb) - 1)));
  endfunction

  function automatic logic [23:0] exp_color(int idx);
    return tbl[idx][23:0];
  endfunction

  task automatic step();
    logic [23:0] cur;
    @(negedge clk);
    cyc++;
    cur = {rgb_r, rgb_g, rgb_b};
    chk(tbl_wr_ready == (cyc % 2 == 1), "R2 slot phase", 32'(tbl_wr_ready), 32'(cyc % 2));
    if (rgb_valid) begin
      if (expq.size() == 0) begin
        chk(0, "R6 unexpected pixel", 32'(cur), 32'h0);
      end else begin
        int idx = expq.pop_front();
        chk(cur == exp_color(idx), "R3 R4 R7 R8 pixel color", 32'(cur), 32'(exp_color(idx)));
      end
      under_armed = 1;
    end else begin
      chk(cur == last_rgb, "R6 color held", 32'(cur), 32'(last_rgb));
    end
    if (underrun) begin
      chk(!rgb_valid && cur == last_rgb, "R9 starve hold", 32'(cur), 32'(last_rgb));
      if (under_armed != 0) under_cnt++;
    end
    last_rgb = cur;
    // word stream
    if (w_hs) begin word_valid = 1'b0; w_hs = 0; end
    if (!word_valid && feed && wq.size() > 0 && $urandom_range(99) >= gap_pct) begin
      word_data  = wq.pop_front();
      word_valid = 1'b1;
      if (rand_mode) bpp_mode = 2'($urandom_range(3));
    end
    if (word_valid && word_ready) begin
      push_word(word_data, int'(bpp_mode));
      w_hs = 1;
      hs_count++;
    end
    // table writes
    if (t_hs) begin tbl_wr_valid = 1'b0; t_hs = 0; end
    if (!tbl_wr_valid && wrq.size() > 0) begin
      {tbl_wr_addr, tbl_wr_data} = wrq.pop_front();
      tbl_wr_valid = 1'b1;
    end
    if (tbl_wr_valid && tbl_wr_ready) begin
      tbl[tbl_wr_addr] = tbl_wr_data;
      t_hs = 1;
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    #(5.0 * 150000);
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=0", cyc);
    finish_run();
  end

  initial begin
    void'($urandom(32'd1234));
    foreach (tbl[i]) tbl[i] = '0;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk({rgb_r, rgb_g, rgb_b} == 24'h0, "R1 rgb reset", 32'({rgb_r, rgb_g, rgb_b}), 32'h0);
    chk(!rgb_valid && !underrun, "R1 strobes reset", 32'({rgb_valid, underrun}), 32'h0);
    chk(word_ready && !tbl_wr_ready, "R1 ready reset", 32'({word_ready, tbl_wr_ready}), 32'h2);
    rst_n = 1'b1;
    cyc = 0;

    // R9: starvation straight after reset
    under_armed = 1;
    repeat (6) step();
    chk(under_cnt == 3, "R9 underrun pulses", 32'(under_cnt), 32'd3);
    under_armed = 0;
    under_cnt = 0;

    // R8: fill the table; entry 5 has only the top byte set (R7)
    for (int i = 0; i < 256; i++) begin
      logic [31:0] v = (i == 5) ? 32'hFF00_0000 : $urandom();
      wrq.push_back({8'(i), v});
    end
    while (wrq.size() > 0 || tbl_wr_valid) step();

    // R5: one word in 8-bit mode, drained to empty; index 5 yields black (R7)
    bpp_mode = 2'd3;
    feed = 1;
    wq.push_back(32'h0905_FE05);
    while (hs_count == 0) step();
    step();
    chk(!word_ready, "R5 busy after accept", 32'(word_ready), 32'h0);
    feed = 0;
    repeat (12) step();
    chk(expq.size() == 0 && word_ready, "R5 drained and ready", 32'(expq.size()), 32'h0);

    // R8: rewrite an entry, then read it back through a pixel in 4-bit mode
    wrq.push_back({8'd9, 32'h00A1_B2C3});
    while (wrq.size() > 0 || tbl_wr_valid) step();
    bpp_mode = 2'd2;
    feed = 1;
    wq.push_back(32'h0000_0009);
    repeat (24) step();
    chk(expq.size() == 0, "R8 rewrite pixels out", 32'(expq.size()), 32'h0);

    // R10: gap-free stream in 2-bit mode
    bpp_mode = 2'd1;
    gap_pct = 0;
    under_cnt = 0;
    under_armed = 0;
    for (int i = 0; i < 6; i++) wq.push_back($urandom());
    while (wq.size() > 0 || word_valid) step();
    chk(under_cnt == 0, "R10 no gap underrun", 32'(under_cnt), 32'h0);
    repeat (40) step();
    under_armed = 0;

    // R3 R4 R8: random words, widths, gaps and table rewrites
    rand_mode = 1;
    gap_pct = 30;
    for (int i = 0; i < 300; i++) begin
      wq.push_back($urandom());
      if ($urandom_range(3) == 0) wrq.push_back({8'($urandom_range(255)), 32'($urandom())});
    end
    while (wq.size() > 0 || word_valid) step();
    repeat (80) step();
    chk(expq.size() == 0, "R5 R6 all pixels emitted", 32'(expq.size()), 32'h0);
    finish_run();
  end

endmodule